// File: doc/BRIEF.md
# Indirect-Access 64-Line Interrupt Controller

This block collects 64 interrupt request lines, numbered 0 to 63, and presents one of them at a time to a host as a single interrupt output together with a vector offset. Each line is either edge-sensitive or level-sensitive. The host sees only three access points: an index register, a data register and an end-of-interrupt register. The 64-bit mask and the 64-bit trigger-mode register are reached indirectly. The host first writes an index, and later data accesses go to the register that index selects.

An edge line latches a sticky request on a rising edge. A level line requests for as long as its input is high. A request that is unmasked and not already in service is a candidate, and the lowest-numbered candidate wins. A three-state arbiter sequences the presentation. In ARB_IDLE nothing is offered. On any candidate the arbiter moves to ARB_PRESENT and latches the winning line. In ARB_PRESENT it keeps following the best candidate. If the candidates vanish it returns to ARB_IDLE. An acknowledge moves it to ARB_SETTLE. ARB_SETTLE lasts one cycle, while the in-service state updates. From ARB_SETTLE the arbiter goes back to ARB_PRESENT if a candidate remains, and to ARB_IDLE otherwise. Software completes service by writing the line number to the end-of-interrupt register.

Top module: `intc64_top`

## Requirements
- R1: After reset the mask reads all ones, the trigger-mode register reads zero, the index reads zero, irq_out is low and nothing is pending or in service.
- R2: A write with reg_sel=0 loads wdata[7:0] into the index. A read with reg_sel=0 returns the index, zero-extended.
- R3: With index 0x40, data accesses (reg_sel=1) read and write the mask. Mask bit n = 1 disables line n.
- R4: With index 0x50, data accesses read and write the trigger-mode register. Bit n = 1 makes line n level-sensitive, and 0 makes it edge-sensitive.
- R5: With any other index, a data write changes nothing and a data read returns zero. A read with reg_sel=2 or 3 returns zero.
- R6: For an edge line, a 0→1 change of irq_in[n] sets a pending bit, also while the line is masked. The bit stays set until line n is acknowledged.
- R7: For a level line, the request equals irq_in[n] in each cycle. Dropping the input withdraws the request.
- R8: The candidates are the lines that are pending, unmasked and not in service. The lowest-numbered candidate is presented.
- R9: vec_out = VEC_BASE + INST_IDX·64·16 + 16·line. With the defaults this is 0x800 + 16·line.
- R10: An acknowledge (ack high while irq_out is high) puts the presented line in service and clears its edge request. irq_out is low in the following cycle.
- R11: A line in service is not presented again until a write with reg_sel=2 whose wdata[5:0] equals its number. That write clears the line's in-service bit.
- R12: The arbiter changes state as follows:
  - ARB_IDLE→ARB_PRESENT on a candidate.
  - ARB_PRESENT→ARB_SETTLE on an acknowledge.
  - ARB_PRESENT→ARB_IDLE when no candidate remains.
  - ARB_SETTLE→ARB_PRESENT or ARB_IDLE, depending on the candidates.
  
  irq_out is high only in ARB_PRESENT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Interrupt request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 index, 1 data, 2 end-of-interrupt |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data for reg_sel |
| ack | input | 1 | Host acknowledge of the presented line |
| irq_out | output | 1 | Interrupt to host |
| vec_out | output | 16 | Vector offset of the presented line |

## Verification
The embedded assertions check the following on every cycle:
- a mask write lands;
- a rising edge on an edge line latches a request;
- an acknowledge sets the in-service bit and silences irq_out for one cycle;
- an end-of-interrupt write clears its bit;
- irq_out only rises after a cycle that had a candidate.

Some behaviours only the bench scenarios can show. These are the lowest-number priority among competing lines, the suppression of a still-asserted level line while it is in service, the withdrawal of a level request, and the zero reads of unimplemented indices. The bench's behavioural model is compared against the outputs each clock to show them.

// File: rtl/intc_pkg.sv
package intc_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE    = 2'd0,
        ARB_PRESENT = 2'd1,
        ARB_SETTLE  = 2'd2
    } arb_state_e;

    localparam logic [1:0] SEL_INDEX = 2'd0;
    localparam logic [1:0] SEL_DATA  = 2'd1;
    localparam logic [1:0] SEL_EOI   = 2'd2;

    localparam int        IDX_W    = 8;
    localparam logic [7:0] IDX_MASK = 8'h40;
    localparam logic [7:0] IDX_TRIG = 8'h50;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int NLINES = 64,
    parameter int LW     = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [NLINES-1:0] wdata,
    output logic [NLINES-1:0] rdata,
    output logic [NLINES-1:0] mask,
    output logic [NLINES-1:0] trig,
    output logic              eoi_fire,
    output logic [LW-1:0]     eoi_line
);
    logic [IDX_W-1:0] index_q;
    logic             data_wr;

    assign data_wr  = reg_wr && (reg_sel == SEL_DATA);
    assign eoi_fire = reg_wr && (reg_sel == SEL_EOI);
    assign eoi_line = wdata[LW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index_q <= '0;
            mask    <= '1;
            trig    <= '0;
        end else begin
            if (reg_wr && reg_sel == SEL_INDEX)
                index_q <= wdata[IDX_W-1:0];
            if (data_wr && index_q == IDX_MASK)
                mask <= wdata;
            if (data_wr && index_q == IDX_TRIG)
                trig <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (reg_sel)
            SEL_INDEX: rdata = NLINES'(index_q);
            SEL_DATA: begin
                if (index_q == IDX_MASK)      rdata = mask;
                else if (index_q == IDX_TRIG) rdata = trig;
            end
            default: rdata = '0;
        endcase
    end

    // R3
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && index_q == IDX_MASK) |=> (mask == $past(wdata)));
endmodule

// File: rtl/intc_capture.sv
module intc_capture #(
    parameter int NLINES = 64,
    parameter int LW     = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_in,
    input  logic [NLINES-1:0] mask,
    input  logic [NLINES-1:0] trig,
    input  logic              ack_fire,
    input  logic [LW-1:0]     ack_line,
    input  logic              eoi_fire,
    input  logic [LW-1:0]     eoi_line,
    output logic [NLINES-1:0] cand
);
    logic [NLINES-1:0] prev_q, pend_edge_q, isr_q;
    logic [NLINES-1:0] rise, pend, ack_bits, eoi_bits;

    assign rise     = irq_in & ~prev_q;
    assign ack_bits = ack_fire ? (NLINES'(1) << ack_line) : '0;
    assign eoi_bits = eoi_fire ? (NLINES'(1) << eoi_line) : '0;

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        assign pend[i] = trig[i] ? irq_in[i] : pend_edge_q[i];
    end

    assign cand = pend & ~mask & ~isr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q      <= '0;
            pend_edge_q <= '0;
            isr_q       <= '0;
        end else begin
            prev_q      <= irq_in;
            pend_edge_q <= ((pend_edge_q & ~ack_bits) | rise) & ~trig;
            isr_q       <= (isr_q & ~eoi_bits) | ack_bits;
        end
    end

    // R6
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_edge_q & $past(rise & ~trig)) == $past(rise & ~trig)));
    // R10
    ack_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> isr_q[$past(ack_line)]);
    // R11
    eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_fire && !(ack_fire && ack_line == eoi_line)) |=> !isr_q[$past(eoi_line)]);
endmodule

// File: rtl/intc_arb.sv
module intc_arb
    import intc_pkg::*;
#(
    parameter int NLINES   = 64,
    parameter int LW       = $clog2(NLINES),
    parameter int VW       = 16,
    parameter int VEC_BASE = 'h800,
    parameter int INST_IDX = 0,
    parameter int SLOT     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] cand,
    input  logic              ack,
    output logic              irq_out,
    output logic [VW-1:0]     vec_out,
    output logic              ack_fire,
    output logic [LW-1:0]     ack_line
);
    localparam int INST_BASE = VEC_BASE + INST_IDX * NLINES * SLOT;

    arb_state_e state_q, state_d;
    logic [LW-1:0] line_q, line_d, best;
    logic          any_cand;

    assign any_cand = |cand;

    always_comb begin
        best = '0;
        for (int i = NLINES - 1; i >= 0; i--)
            if (cand[i]) best = LW'(i);
    end

    assign ack_fire = (state_q == ARB_PRESENT) && ack;
    assign ack_line = line_q;

    always_comb begin
        state_d = state_q;
        line_d  = line_q;
        unique case (state_q)
            ARB_IDLE, ARB_SETTLE: begin
                if (any_cand) begin
                    state_d = ARB_PRESENT;
                    line_d  = best;
                end else begin
                    state_d = ARB_IDLE;
                end
            end
            ARB_PRESENT: begin
                if (ack) begin
                    state_d = ARB_SETTLE;
                end else if (any_cand) begin
                    line_d = best;
                end else begin
                    state_d = ARB_IDLE;
                end
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            line_q  <= '0;
        end else begin
            state_q <= state_d;
            line_q  <= line_d;
        end
    end

    always_comb begin
        irq_out = (state_q == ARB_PRESENT);
        vec_out = VW'(INST_BASE) + VW'(line_q) * VW'(SLOT);
    end

    // R10
    after_ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> !irq_out);
    // R12
    irq_from_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(any_cand));
endmodule

// File: rtl/intc64_top.sv
module intc64_top #(
    parameter int NLINES   = 64,
    parameter int VW       = 16,
    parameter int VEC_BASE = 'h800,
    parameter int INST_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_in,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [NLINES-1:0] wdata,
    output logic [NLINES-1:0] rdata,
    input  logic              ack,
    output logic              irq_out,
    output logic [VW-1:0]     vec_out
);
    localparam int LW = $clog2(NLINES);

    logic [NLINES-1:0] mask, trig, cand;
    logic              eoi_fire, ack_fire;
    logic [LW-1:0]     eoi_line, ack_line;

    intc_regs #(.NLINES(NLINES), .LW(LW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .wdata(wdata), .rdata(rdata), .mask(mask), .trig(trig),
        .eoi_fire(eoi_fire), .eoi_line(eoi_line)
    );

    intc_capture #(.NLINES(NLINES), .LW(LW)) u_cap (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask(mask), .trig(trig),
        .ack_fire(ack_fire), .ack_line(ack_line),
        .eoi_fire(eoi_fire), .eoi_line(eoi_line), .cand(cand)
    );

    intc_arb #(.NLINES(NLINES), .LW(LW), .VW(VW), .VEC_BASE(VEC_BASE),
               .INST_IDX(INST_IDX), .SLOT(16)) u_arb (
        .clk(clk), .rst_n(rst_n), .cand(cand), .ack(ack),
        .irq_out(irq_out), .vec_out(vec_out),
        .ack_fire(ack_fire), .ack_line(ack_line)
    );
endmodule

// File: tb/sim_intc64_top.sv
module sim_intc64_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        ack = 1'b0;
    logic        irq_out;
    logic [15:0] vec_out;

    int    checks = 0;
    int    fails = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    intc64_top u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata), .ack(ack),
        .irq_out(irq_out), .vec_out(vec_out)
    );

    // behavioural reference model
    logic [63:0] m_mask, m_trig, m_pedge, m_isr, m_prev;
    logic [7:0]  m_idx;
    int          m_st, m_line;

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = '1; m_trig = '0; m_pedge = '0; m_isr = '0; m_prev = '0;
            m_idx = '0; m_st = 0; m_line = 0;
        end else if (!done) begin
            logic [63:0] pend, cand, exp_rd, ackb;
            int best;
            bit ackf;
            chk("irq_out", {63'b0, irq_out}, {63'b0, m_st == 1});
            chk("vec_out", {48'b0, vec_out}, 64'(32'h800 + m_line * 16));
            exp_rd = '0;
            if (reg_sel == 2'd0) exp_rd = {56'b0, m_idx};
            else if (reg_sel == 2'd1 && m_idx == 8'h40) exp_rd = m_mask;
            else if (reg_sel == 2'd1 && m_idx == 8'h50) exp_rd = m_trig;
            chk("rdata", rdata, exp_rd);

            best = -1;
            for (int n = 0; n < 64; n++) begin
                pend[n] = m_trig[n] ? irq_in[n] : m_pedge[n];
                cand[n] = pend[n] & ~m_mask[n] & ~m_isr[n];
                if (cand[n] && best < 0) best = n;
            end
            ackf = (m_st == 1) && ack;
            ackb = '0;
            if (ackf) ackb[m_line] = 1'b1;
            for (int n = 0; n < 64; n++) begin
                if (m_trig[n]) m_pedge[n] = 1'b0;
                else if (irq_in[n] && !m_prev[n]) m_pedge[n] = 1'b1;
                else if (ackb[n]) m_pedge[n] = 1'b0;
            end
            m_prev = irq_in;
            if (reg_wr && reg_sel == 2'd2) m_isr[wdata[5:0]] = 1'b0;
            if (ackf) m_isr[m_line] = 1'b1;
            if (reg_wr && reg_sel == 2'd1 && m_idx == 8'h40) m_mask = wdata;
            if (reg_wr && reg_sel == 2'd1 && m_idx == 8'h50) m_trig = wdata;
            if (reg_wr && reg_sel == 2'd0) m_idx = wdata[7:0];
            if (m_st == 1) begin
                if (ack) m_st = 2;
                else if (best >= 0) m_line = best;
                else m_st = 0;
            end else begin
                if (best >= 0) begin m_st = 1; m_line = best; end
                else m_st = 0;
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 reset state
        cur_req = "R1";
        idle(3);
        rst_n = 1'b1;
        reg_sel = 2'd0; idle(2);
        wr(2'd0, 64'h40); reg_sel = 2'd1; idle(2);
        wr(2'd0, 64'h50); reg_sel = 2'd1; idle(2);
        // R2 index readback
        cur_req = "R2";
        wr(2'd0, 64'h1A5); reg_sel = 2'd0; idle(2);
        // R6 edge latch while masked, then R3 unmask
        cur_req = "R6";
        irq_in[5] = 1'b1; irq_in[3] = 1'b1; idle(2);
        irq_in[5] = 1'b0; irq_in[3] = 1'b0; idle(3);
        cur_req = "R3";
        wr(2'd0, 64'h40); wr(2'd1, 64'h0); reg_sel = 2'd1; idle(3);
        // R8 line 3 beats line 5; R9 vector
        cur_req = "R8"; idle(2);
        cur_req = "R10"; do_ack(); idle(3);
        cur_req = "R9"; idle(1); do_ack(); idle(2);
        cur_req = "R11";
        wr(2'd2, 64'd3); wr(2'd2, 64'd5); idle(2);
        // R4 / R7 level line 10
        cur_req = "R4";
        wr(2'd0, 64'h50); wr(2'd1, 64'h400); reg_sel = 2'd1; idle(2);
        cur_req = "R7";
        irq_in[10] = 1'b1; idle(3);
        irq_in[10] = 1'b0; idle(3);
        irq_in[10] = 1'b1; idle(2);
        cur_req = "R11";
        do_ack(); idle(5);
        wr(2'd2, 64'd10); idle(3);
        do_ack(); irq_in[10] = 1'b0; idle(2);
        wr(2'd2, 64'd10); idle(2);
        // R5 unimplemented index
        cur_req = "R5";
        wr(2'd0, 64'h60); wr(2'd1, '1); reg_sel = 2'd1; idle(2);
        reg_sel = 2'd2; idle(1); reg_sel = 2'd3; idle(1);
        wr(2'd0, 64'h40); reg_sel = 2'd1; idle(2);
        // R8 boundaries: line 63 vs masked line 0
        cur_req = "R8";
        wr(2'd1, 64'h1);
        irq_in[63] = 1'b1; irq_in[0] = 1'b1; idle(1);
        irq_in[63] = 1'b0; irq_in[0] = 1'b0; idle(3);
        wr(2'd1, 64'h0); idle(3);
        cur_req = "R12";
        do_ack(); idle(3); do_ack(); idle(3);
        cur_req = "R11";
        wr(2'd2, 64'h40); wr(2'd2, 64'd63); idle(3);
        finish_run();
    end
endmodule